// File: doc/BRIEF.md
# Two-Wire Serial Slave Address Front End

This block is the receive-side front end of a two-wire serial slave. It oversamples the serial clock and data lines in the system clock domain, recognises start and stop conditions, and shifts in the seven address bits and the direction bit that follow each start. It then decides whether the transfer is meant for this slave by comparing the received address with a programmed own-address. The comparison covers only the bit positions enabled by a programmable mask, so one slave can answer a whole group of addresses.

When the address is accepted, the block pulls the data line low for the acknowledge clock period. It then holds an "addressed" status until a stop or a new start. When the address is not accepted, it leaves the line alone and waits for the next start.

A processor programs the own-address and the mask through a single byte-wide register location. The top bit of the written byte chooses the destination. Reads of that location return the own-address only.

Top module: `twowire_addr_slave`

## Requirements
- R1: A falling data line while the synchronized clock line is high is a start. It raises `start_det_o` for one cycle and restarts address collection, including when a start arrives in the middle of an address.
- R2: A rising data line while the synchronized clock line is high is a stop. It raises `stop_det_o` for one cycle and clears `addr_match_o` and `sda_pull_o` in the same cycle.
- R3: Address bits are sampled on rising edges of the clock line, most significant bit first: seven address bits, then the direction bit.
- R4: On an accepted address, `rw_flag_o` takes the direction bit: 0 for a master write, 1 for a master read.
- R5: The address is accepted when (received & mask) == (own & mask). `sda_pull_o` (1 = pull the line low) then rises on the clock-line falling edge that ends the direction bit and drops on the next falling edge. `addr_match_o` stays high from the acceptance until a stop or start.
- R6: A rejected address leaves `sda_pull_o` and `addr_match_o` at 0. All further bits are ignored until the next start.
- R7: With own-address 124 and mask binary 1111100, addresses 124 to 127 are accepted and 123 is rejected.
- R8: A write with `reg_wdata[7]`=1 loads the mask from bits 6:0. A write with `reg_wdata[7]`=0 loads the own-address from bits 6:0.
- R9: `reg_rdata` always shows {0, own-address}. A mask write leaves it unchanged.
- R10: A repeated start after an accepted address starts a fresh address cycle, which is accepted or rejected on its own.
- R11: After reset the own-address is 0, the mask is 1111111, and all status outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_pull_o | output | 1 | Open-drain pull-down enable for the data line |
| reg_wr_en | input | 1 | Write strobe for the shared address/mask location |
| reg_wdata | input | 8 | Write byte; bit 7 selects mask (1) or own-address (0) |
| reg_rdata | output | 8 | Read value: own-address with bit 7 zero |
| rw_flag_o | output | 1 | Direction bit of the last accepted address |
| addr_match_o | output | 1 | High while this slave is addressed |
| start_det_o | output | 1 | One-cycle pulse on a start condition |
| stop_det_o | output | 1 | One-cycle pulse on a stop condition |

## Verification
The hardest situation to reach from the ports is the acknowledge window. There the block's own pull-down is on the data line the block samples. A wrong release point would therefore look like a start or a stop. The bench models the pad as a wired AND of the master's drive and `sda_pull_o`, so the design sees its own acknowledge. Repeated starts are issued directly after that window and also part-way through an address, which exercises the restart paths.

// File: rtl/tw_slave_pkg.sv
// Shared types for the two-wire slave address front end.
package tw_slave_pkg;
    // Address-phase state: idle, collecting bits, driving acknowledge, selected.
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_SEL
    } tw_state_t;
endpackage

// File: rtl/tw_line_sync.sv
// Multi-flop synchronizer for the serial lines, plus one extra flop that
// holds the previous synchronized value for edge detection.
// Assumes the lines idle high, so every flop resets to 1. STAGES >= 2.
module tw_line_sync #(
    parameter int N_LINES = 2,
    parameter int STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] raw_i,
    output logic [N_LINES-1:0] now_o,
    output logic [N_LINES-1:0] prev_o
);
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        logic              last_q;

        // Shift the raw pad value through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw_i[g]};
        end

        // Keep the previous synchronized sample for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) last_q <= 1'b1;
            else        last_q <= chain[STAGES-1];
        end

        assign now_o[g]  = chain[STAGES-1];
        assign prev_o[g] = last_q;
    end
endmodule

// File: rtl/tw_addr_regs.sv
// Own-address and mask registers behind one shared write location.
// The top bit of the written word selects the mask (1) or the own-address (0).
// Reads return the own-address only; the mask is write-only.
module tw_addr_regs #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW:0]   wdata,
    output logic [AW-1:0] own_o,
    output logic [AW-1:0] mask_o,
    output logic [AW:0]   rdata_o
);
    // Load whichever register the select bit names.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_o  <= '0;
            mask_o <= '1;
        end else if (wr_en) begin
            if (wdata[AW]) mask_o <= wdata[AW-1:0];
            else           own_o  <= wdata[AW-1:0];
        end
    end

    // Read path exposes the own-address with a zero select bit.
    assign rdata_o = {1'b0, own_o};
endmodule

// File: rtl/tw_addr_fsm.sv
// Address-phase controller. Decodes start/stop and clock edges from the
// synchronized lines, shifts in address plus direction bit MSB first, and
// runs the masked compare. On a hit it pulls the data line low for one clock
// period. Assumes the inputs are already synchronized to clk.
module tw_addr_fsm
    import tw_slave_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_now,
    input  logic          scl_prev,
    input  logic          sda_now,
    input  logic          sda_prev,
    input  logic [AW-1:0] own_addr,
    input  logic [AW-1:0] addr_mask,
    output logic          pull_o,
    output logic          match_o,
    output logic          rw_o,
    output logic          start_p_o,
    output logic          stop_p_o
);
    localparam int FRAME = AW + 1;
    localparam int CW    = $clog2(FRAME + 1);
    localparam logic [CW-1:0] FRAME_C = CW'(FRAME);

    tw_state_t     state;
    logic [CW-1:0] bit_cnt;
    logic [AW:0]   shreg;
    logic          start_ev, stop_ev, scl_rise, scl_fall, hit;

    // Line events seen on the synchronized samples.
    always_comb begin
        start_ev = scl_now & scl_prev & sda_prev & ~sda_now;
        stop_ev  = scl_now & scl_prev & ~sda_prev & sda_now;
        scl_rise = scl_now & ~scl_prev;
        scl_fall = ~scl_now & scl_prev;
        hit      = ((shreg[AW:1] & addr_mask) == (own_addr & addr_mask));
    end

    // Address-phase sequencing and acknowledge drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            pull_o    <= 1'b0;
            rw_o      <= 1'b0;
            start_p_o <= 1'b0;
            stop_p_o  <= 1'b0;
        end else begin
            start_p_o <= start_ev;
            stop_p_o  <= stop_ev;
            if (start_ev) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                pull_o  <= 1'b0;
            end else if (stop_ev) begin
                state  <= ST_IDLE;
                pull_o <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise && bit_cnt != FRAME_C) begin
                            shreg   <= {shreg[AW-1:0], sda_now};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == FRAME_C) begin
                            if (hit) begin
                                state  <= ST_ACK;
                                pull_o <= 1'b1;
                                rw_o   <= shreg[0];
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            state  <= ST_SEL;
                            pull_o <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Selected from acceptance until the next start or stop.
    assign match_o = (state == ST_ACK) || (state == ST_SEL);
endmodule

// File: rtl/twowire_addr_slave.sv
// Top of the two-wire slave address front end: line synchronizer, shared
// address/mask registers and address-phase controller. The data line output
// is an active-high pull-down enable for an open-drain pad.
module twowire_addr_slave #(
    parameter int AW          = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_in,
    input  logic        sda_in,
    output logic        sda_pull_o,
    input  logic        reg_wr_en,
    input  logic [AW:0] reg_wdata,
    output logic [AW:0] reg_rdata,
    output logic        rw_flag_o,
    output logic        addr_match_o,
    output logic        start_det_o,
    output logic        stop_det_o
);
    logic [1:0]    line_now, line_prev;
    logic [AW-1:0] own_addr, addr_mask;

    tw_line_sync #(.N_LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({sda_in, scl_in}),
        .now_o  (line_now),
        .prev_o (line_prev)
    );

    tw_addr_regs #(.AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wdata   (reg_wdata),
        .own_o   (own_addr),
        .mask_o  (addr_mask),
        .rdata_o (reg_rdata)
    );

    tw_addr_fsm #(.AW(AW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_now   (line_now[0]),
        .scl_prev  (line_prev[0]),
        .sda_now   (line_now[1]),
        .sda_prev  (line_prev[1]),
        .own_addr  (own_addr),
        .addr_mask (addr_mask),
        .pull_o    (sda_pull_o),
        .match_o   (addr_match_o),
        .rw_o      (rw_flag_o),
        .start_p_o (start_det_o),
        .stop_p_o  (stop_det_o)
    );
endmodule

// File: rtl/twowire_addr_slave_chk.sv
// Property checker for twowire_addr_slave, attached with bind below.
module twowire_addr_slave_chk #(
    parameter int AW = 7
) (
    input logic        clk,
    input logic        rst_n,
    input logic        sda_pull_o,
    input logic        addr_match_o,
    input logic        start_det_o,
    input logic        stop_det_o,
    input logic        reg_wr_en,
    input logic [AW:0] reg_wdata,
    input logic [AW:0] reg_rdata
);
    // R5: the line is only pulled while the slave is addressed.
    p_pull_needs_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull_o |-> addr_match_o);

    // R2: a stop leaves the slave unaddressed with the line released.
    p_stop_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det_o |-> (!addr_match_o && !sda_pull_o));

    // R1: start and stop pulses never coincide.
    p_start_stop_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_det_o && stop_det_o));

    // R9: a mask write does not change the read value.
    p_mask_write_hidden_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wdata[AW]) |=> $stable(reg_rdata));

    // R8: an own-address write shows up on the read port next cycle.
    p_own_write_visible_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !reg_wdata[AW]) |=> (reg_rdata == {1'b0, $past(reg_wdata[AW-1:0])}));
endmodule

bind twowire_addr_slave twowire_addr_slave_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sda_pull_o   (sda_pull_o),
    .addr_match_o (addr_match_o),
    .start_det_o  (start_det_o),
    .stop_det_o   (stop_det_o),
    .reg_wr_en    (reg_wr_en),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata)
);

// File: tb/twowire_addr_slave_test.sv
`timescale 1ns/1ps
module twowire_addr_slave_test;
    localparam int H = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sda_pull_o, rw_flag_o, addr_match_o, start_det_o, stop_det_o;
    logic       sda_line;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    // Open-drain pad: wired AND of master drive and slave pull-down.
    assign sda_line = sda_m & ~sda_pull_o;

    twowire_addr_slave uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (scl_m),
        .sda_in       (sda_line),
        .sda_pull_o   (sda_pull_o),
        .reg_wr_en    (reg_wr_en),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .rw_flag_o    (rw_flag_o),
        .addr_match_o (addr_match_o),
        .start_det_o  (start_det_o),
        .stop_det_o   (stop_det_o)
    );

    // ---------------- behavioural reference model ----------------
    bit scl_h[$];
    bit sda_h[$];
    int m_phase;  // 0 idle, 1 address, 2 acknowledge, 3 selected
    int m_cnt, m_byte, m_own, m_mask;
    bit m_pull, m_match, m_rw, m_start, m_stop;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit sc, sp, dc, dp;
        scl_h.push_front(scl_m);
        sda_h.push_front(sda_line);
        if (scl_h.size() > 4) begin
            void'(scl_h.pop_back());
            void'(sda_h.pop_back());
        end
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_byte = 0; m_own = 0; m_mask = 127;
            m_pull = 0; m_rw = 0; m_start = 0; m_stop = 0;
        end else begin
            sc = (scl_h.size() > 2) ? scl_h[2] : 1'b1;
            sp = (scl_h.size() > 3) ? scl_h[3] : 1'b1;
            dc = (sda_h.size() > 2) ? sda_h[2] : 1'b1;
            dp = (sda_h.size() > 3) ? sda_h[3] : 1'b1;
            m_start = sc && sp && dp && !dc;
            m_stop  = sc && sp && !dp && dc;
            if (m_start) begin
                m_phase = 1; m_cnt = 0; m_byte = 0; m_pull = 0;
            end else if (m_stop) begin
                m_phase = 0; m_pull = 0;
            end else if (m_phase == 1) begin
                if (sc && !sp && m_cnt < 8) begin
                    m_byte = ((m_byte << 1) | int'(dc)) & 255;
                    m_cnt++;
                end else if (!sc && sp && m_cnt == 8) begin
                    if ((((m_byte >> 1) & m_mask)) == (m_own & m_mask)) begin
                        m_phase = 2; m_pull = 1; m_rw = m_byte[0];
                    end else m_phase = 0;
                end
            end else if (m_phase == 2) begin
                if (!sc && sp) begin m_phase = 3; m_pull = 0; end
            end
            if (reg_wr_en) begin
                if (reg_wdata[7]) m_mask = int'(reg_wdata[6:0]);
                else              m_own  = int'(reg_wdata[6:0]);
            end
        end
        m_match = (m_phase == 2) || (m_phase == 3);
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check(start_det_o == m_start, "R1 start pulse", start_det_o, m_start);
            check(stop_det_o == m_stop, "R2 stop pulse", stop_det_o, m_stop);
            check(sda_pull_o == m_pull, "R5 ack pull", sda_pull_o, m_pull);
            check(addr_match_o == m_match, "R6 addressed", addr_match_o, m_match);
            check(rw_flag_o == m_rw, "R4 direction", rw_flag_o, m_rw);
            check(reg_rdata == 8'(m_own), "R9 read value", reg_rdata, m_own);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic reg_write(input logic [7:0] d);
        step(1);
        reg_wr_en = 1'b1; reg_wdata = d;
        step(1);
        reg_wr_en = 1'b0;
        step(1);
    endtask

    task automatic bus_start();
        step(2); sda_m = 1'b1;
        step(H); scl_m = 1'b1;
        step(H); sda_m = 1'b0;
        step(H); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        step(2); sda_m = 1'b0;
        step(H); scl_m = 1'b1;
        step(H); sda_m = 1'b1;
        step(H);
    endtask

    task automatic send_bit(input bit b);
        step(2); sda_m = b;
        step(H); scl_m = 1'b1;
        step(H); scl_m = 1'b0;
    endtask

    // Address, direction bit, then the acknowledge clock; returns the pull seen.
    task automatic send_addr(input int a, input bit rw, output bit acked);
        for (int i = 6; i >= 0; i--) send_bit(a[i]);
        send_bit(rw);
        step(2); sda_m = 1'b1;
        step(H); scl_m = 1'b1;
        step(2); acked = sda_pull_o;
        step(H - 2); scl_m = 1'b0;
    endtask

    task automatic expect_ack(input int a, input bit rw, input bit exp, input string req);
        bit got;
        send_addr(a, rw, got);
        check(got == exp, req, got, exp);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // ---------------- test sequence ----------------
    initial begin
        bit got;
        step(4);
        rst_n = 1'b1;
        step(2);
        // R11: reset state
        check(reg_rdata == 8'h00, "R11 own after reset", reg_rdata, 0);
        check(!sda_pull_o && !addr_match_o && !rw_flag_o, "R11 outputs idle",
              {sda_pull_o, addr_match_o, rw_flag_o}, 0);
        // Default mask is all ones: exact match on address 0.
        bus_start();
        expect_ack(0, 1'b0, 1'b1, "R11 default mask exact match");
        bus_stop();

        // R8 / R9: shared register location
        reg_write(8'h50);
        check(reg_rdata == 8'h50, "R8 own write", reg_rdata, 8'h50);
        reg_write(8'hFF);
        check(reg_rdata == 8'h50, "R9 mask hidden", reg_rdata, 8'h50);

        // R5 / R4: exact hit, master write
        bus_start();
        expect_ack(8'h50, 1'b0, 1'b1, "R5 exact hit");
        check(addr_match_o == 1'b1, "R5 addressed held", addr_match_o, 1);
        check(rw_flag_o == 1'b0, "R4 write direction", rw_flag_o, 0);
        bus_stop();
        check(addr_match_o == 1'b0, "R2 stop clears", addr_match_o, 0);

        // R6: miss by one bit
        bus_start();
        expect_ack(8'h51, 1'b1, 1'b0, "R6 miss");
        check(addr_match_o == 1'b0, "R6 not addressed", addr_match_o, 0);
        // R6: further bits that would match are ignored without a start
        expect_ack(8'h50, 1'b0, 1'b0, "R6 ignored bits");
        bus_stop();

        // R3: bit-reversed address must not match
        bus_start();
        expect_ack(8'h05, 1'b0, 1'b0, "R3 MSB first");
        bus_stop();

        // R7: masked group 124..127
        reg_write(8'h7C);
        reg_write(8'h80 | 8'h7C);
        for (int a = 123; a <= 127; a++) begin
            bus_start();
            expect_ack(a, 1'b1, (a >= 124), "R7 masked group");
            if (a >= 124) check(rw_flag_o == 1'b1, "R4 read direction", rw_flag_o, 1);
            bus_stop();
        end

        // R10: repeated starts after acceptance
        bus_start();
        expect_ack(125, 1'b0, 1'b1, "R10 first address");
        bus_start();
        expect_ack(16, 1'b0, 1'b0, "R10 repeated start miss");
        check(addr_match_o == 1'b0, "R10 cleared by miss", addr_match_o, 0);
        bus_start();
        expect_ack(126, 1'b1, 1'b1, "R10 repeated start hit");
        bus_stop();

        // R1: start in the middle of an address restarts collection
        bus_start();
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_start();
        send_addr(127, 1'b0, got);
        check(got == 1'b1, "R1 restart mid-address", got, 1);
        bus_stop();

        step(10);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule